// File: doc/BRIEF.md
# 100BASE-X Receive Delimiter Tracker

This block sits behind the descrambler of a 100 Mbps receive path. It takes one 5-bit code group per symbol clock. It keeps the previous group and forms a 10-bit window from the previous group followed by the new one. From that window it decides whether a frame begins or ends, or whether the line carries false carrier. It drives carrier sense, data valid, error and a 4-bit nibble toward the MAC. A sticky status bit records that a bad start delimiter was seen, and management logic can read it.

Each nibble is issued for the older group of the window. The group after it then serves as lookahead, so an end delimiter can be recognised before its first group is emitted. A code group presented on clock edge e is reflected on the outputs after edge e+1. The bit order within a group is as written (leftmost bit first), and the window is {older group, newer group}.

Top module: `pcs_rx_delim`

## Requirements
- R1: A synchronous active-high reset clears crs, rx_dv, rx_er, rx_nib and bad_ssd. After reset the previous group counts as idle (11111).
- R2: In the idle state the window J(11000) followed by K(10001) starts a frame. Both the J and the K group are output with crs=1, rx_dv=1, rx_er=0 and rx_nib=4'b0101.
- R3: Inside a frame, each data group is decoded to its nibble by the 4B5B table (0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101), with crs=rx_dv=1 and rx_er=0.
- R4: Inside a frame, a group that is not a data symbol and does not start an end or idle window is output with rx_er=1, rx_nib=0, and crs and rx_dv still high.
- R5: Inside a frame, the window T(01101) followed by R(00111) ends the frame. The T and R groups are both output as idle (crs=rx_dv=rx_er=0, rx_nib=0).
- R6: Inside a frame, an I,I window ends the frame early. The first I is output with crs=rx_dv=rx_er=1 and rx_nib=0, and the outputs are idle from the next nibble on.
- R7: In the idle state, a window that is neither I,I nor J,K but holds at least two separate runs of zero bits is false carrier. Its older group and every later group are output with crs=1, rx_dv=0, rx_er=1 and rx_nib=4'b1110, until an I,I window is seen. The first I of that window is output idle.
- R8: bad_ssd goes high together with the first false-carrier nibble and stays high until reset.
- R9: While false carrier is held, a J,K window does not start a frame.
- R10: In the idle state, a window other than I,I and J,K with fewer than two zero runs is ignored: the outputs stay idle and bad_ssd does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| cg_in | input | 5 | Descrambled code group, one per clock |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_nib | output | 4 | Receive nibble |
| bad_ssd | output | 1 | Sticky bad start delimiter status |

## Verification
Two decisions can fall on the same window. When an I group is the older half of an I,I window inside a frame, it is both an invalid data symbol and the start of a premature end. The bench sends a frame that stops with idles and expects one error nibble with carrier still up, followed by idle rather than a string of error nibbles. The other collision comes when the I,I window that releases false carrier is directly followed by J,K. The bench drives exactly that sequence and requires the start to be accepted only once the idle window has cleared the hold, and not while false carrier is still active.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * CG_W;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_SSD1 = 5'b11000;
  localparam logic [CG_W-1:0] CG_SSD2 = 5'b10001;
  localparam logic [CG_W-1:0] CG_ESD1 = 5'b01101;
  localparam logic [CG_W-1:0] CG_ESD2 = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_PREAMBLE = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_FALSE    = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOF2, ST_BODY, ST_TAIL, ST_FCAR
  } rx_state_t;

  typedef struct packed {
    logic idle_pair;
    logic start_pair;
    logic end_pair;
    logic noisy;
  } win_class_t;

  typedef struct packed {
    logic              crs;
    logic              dv;
    logic              er;
    logic [NIB_W-1:0]  nib;
  } mac_rx_t;

  // returns {valid, nibble}
  function automatic logic [NIB_W:0] sym_decode(input logic [CG_W-1:0] g);
    case (g)
      5'b11110: sym_decode = {1'b1, 4'h0};
      5'b01001: sym_decode = {1'b1, 4'h1};
      5'b10100: sym_decode = {1'b1, 4'h2};
      5'b10101: sym_decode = {1'b1, 4'h3};
      5'b01010: sym_decode = {1'b1, 4'h4};
      5'b01011: sym_decode = {1'b1, 4'h5};
      5'b01110: sym_decode = {1'b1, 4'h6};
      5'b01111: sym_decode = {1'b1, 4'h7};
      5'b10010: sym_decode = {1'b1, 4'h8};
      5'b10011: sym_decode = {1'b1, 4'h9};
      5'b10110: sym_decode = {1'b1, 4'hA};
      5'b10111: sym_decode = {1'b1, 4'hB};
      5'b11010: sym_decode = {1'b1, 4'hC};
      5'b11011: sym_decode = {1'b1, 4'hD};
      5'b11100: sym_decode = {1'b1, 4'hE};
      5'b11101: sym_decode = {1'b1, 4'hF};
      default:  sym_decode = '0;
    endcase
  endfunction
endpackage

// File: rtl/cg_history.sv
module cg_history
  import pcs_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CG_W-1:0]  cg_in,
  output logic [WIN_W-1:0] win
);
  logic [CG_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= CG_IDLE;
    else     prev_q <= cg_in;
  end

  assign win = {prev_q, cg_in};
endmodule

// File: rtl/win_classify.sv
module win_classify
  import pcs_rx_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  output win_class_t       cls
);
  logic [WIN_W-1:0] run_start;
  logic [$clog2(WIN_W+1)-1:0] runs;

  // a zero whose more significant neighbour is one (or the edge) opens a run
  assign run_start[WIN_W-1] = ~win[WIN_W-1];
  for (genvar i = 0; i < WIN_W-1; i++) begin : g_run
    assign run_start[i] = ~win[i] & win[i+1];
  end

  always_comb begin
    runs = '0;
    for (int k = 0; k < WIN_W; k++) runs = runs + run_start[k];
  end

  assign cls.idle_pair  = (win == {CG_IDLE, CG_IDLE});
  assign cls.start_pair = (win == {CG_SSD1, CG_SSD2});
  assign cls.end_pair   = (win == {CG_ESD1, CG_ESD2});
  assign cls.noisy      = (runs >= 2);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import pcs_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  win_class_t       cls,
  input  logic [CG_W-1:0]  older,
  output mac_rx_t          rx_q,
  output logic             bad_q
);
  rx_state_t st_q, st_d;
  mac_rx_t   rx_d;
  logic      bad_set;
  logic [NIB_W:0] dec;

  localparam mac_rx_t OUT_IDLE = '{crs: 1'b0, dv: 1'b0, er: 1'b0, nib: '0};
  localparam mac_rx_t OUT_PRE  = '{crs: 1'b1, dv: 1'b1, er: 1'b0, nib: NIB_PREAMBLE};
  localparam mac_rx_t OUT_FC   = '{crs: 1'b1, dv: 1'b0, er: 1'b1, nib: NIB_FALSE};
  localparam mac_rx_t OUT_CUT  = '{crs: 1'b1, dv: 1'b1, er: 1'b1, nib: '0};

  assign dec = sym_decode(older);

  always_comb begin
    st_d    = st_q;
    rx_d    = OUT_IDLE;
    bad_set = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cls.start_pair) begin
          st_d = ST_SOF2;
          rx_d = OUT_PRE;
        end else if (!cls.idle_pair && cls.noisy) begin
          st_d    = ST_FCAR;
          rx_d    = OUT_FC;
          bad_set = 1'b1;
        end
      end
      ST_SOF2: begin
        st_d = ST_BODY;
        rx_d = OUT_PRE;
      end
      ST_BODY: begin
        if (cls.end_pair) begin
          st_d = ST_TAIL;
        end else if (cls.idle_pair) begin
          st_d = ST_IDLE;
          rx_d = OUT_CUT;
        end else begin
          rx_d.crs = 1'b1;
          rx_d.dv  = 1'b1;
          rx_d.er  = ~dec[NIB_W];
          rx_d.nib = dec[NIB_W] ? dec[NIB_W-1:0] : '0;
        end
      end
      ST_TAIL: st_d = ST_IDLE;
      ST_FCAR: begin
        if (cls.idle_pair) st_d = ST_IDLE;
        else               rx_d = OUT_FC;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rx_q  <= OUT_IDLE;
      bad_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rx_q  <= rx_d;
      bad_q <= bad_q | bad_set;
    end
  end
endmodule

// File: rtl/pcs_rx_delim.sv
module pcs_rx_delim
  import pcs_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CG_W-1:0]  cg_in,
  output logic             crs,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [NIB_W-1:0] rx_nib,
  output logic             bad_ssd
);
  logic [WIN_W-1:0] win;
  win_class_t       cls;
  mac_rx_t          rx_q;

  cg_history u_hist (.clk(clk), .rst(rst), .cg_in(cg_in), .win(win));

  win_classify u_cls (.win(win), .cls(cls));

  rx_frame_fsm u_fsm (
    .clk(clk), .rst(rst), .cls(cls),
    .older(win[WIN_W-1:CG_W]),
    .rx_q(rx_q), .bad_q(bad_ssd)
  );

  assign crs    = rx_q.crs;
  assign rx_dv  = rx_q.dv;
  assign rx_er  = rx_q.er;
  assign rx_nib = rx_q.nib;
endmodule

// File: rtl/pcs_rx_delim_chk.sv
module pcs_rx_delim_chk (
  input logic       clk,
  input logic       rst,
  input logic       crs,
  input logic       rx_dv,
  input logic       rx_er,
  input logic [3:0] rx_nib,
  input logic       bad_ssd
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!crs && !rx_dv && !rx_er && rx_nib == 4'b0000 && !bad_ssd));

  // R7
  dv_under_crs_chk: assert property (@(posedge clk) disable iff (rst)
    rx_dv |-> crs);

  // R7
  fc_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (crs && !rx_dv) |-> (rx_er && rx_nib == 4'b1110));

  // R8
  sticky_bad_chk: assert property (@(posedge clk) disable iff (rst)
    bad_ssd |=> bad_ssd);

  // R8
  bad_with_fc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bad_ssd) |-> (crs && !rx_dv && rx_er));

  // R2
  sof_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_dv) |-> (rx_nib == 4'b0101 && !rx_er && crs));
endmodule

bind pcs_rx_delim pcs_rx_delim_chk u_chk (
  .clk(clk), .rst(rst), .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er),
  .rx_nib(rx_nib), .bad_ssd(bad_ssd)
);

// File: tb/sim_pcs_rx_delim.sv
module sim_pcs_rx_delim;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] cg  = 5'b11111;
  logic       crs, rx_dv, rx_er, bad_ssd;
  logic [3:0] rx_nib;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pcs_rx_delim u0 (
    .clk(clk), .rst(rst), .cg_in(cg), .crs(crs), .rx_dv(rx_dv),
    .rx_er(rx_er), .rx_nib(rx_nib), .bad_ssd(bad_ssd)
  );

  // ---- behavioural reference ----
  logic [4:0] data_codes[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                 5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                 5'b11010, 5'b11011, 5'b11100, 5'b11101};
  logic [4:0] hist[$];
  string      mode;      // "quiet", "sof", "frame", "drain", "false"
  logic [6:0] expv;      // {crs, dv, er, nib}
  logic       exp_bad;
  string      tag;

  function automatic int zero_runs(input logic [9:0] w);
    int n = 0;
    bit in_run = 0;
    for (int b = 9; b >= 0; b--) begin
      if (!w[b] && !in_run) n++;
      in_run = !w[b];
    end
    return n;
  endfunction

  function automatic int lookup(input logic [4:0] g);
    for (int k = 0; k < 16; k++) if (data_codes[k] == g) return k;
    return -1;
  endfunction

  task automatic model_reset();
    hist.delete();
    hist.push_back(5'b11111);
    mode = "quiet";
    expv = '0;
    exp_bad = 0;
    tag = "R1";
  endtask

  task automatic model_step(input logic [4:0] g);
    logic [4:0] a;
    logic [9:0] w;
    int d;
    a = hist[0];
    w = {a, g};
    void'(hist.pop_front());
    hist.push_back(g);
    if (mode == "quiet") begin
      if (a == 5'b11000 && g == 5'b10001) begin
        expv = {3'b110, 4'b0101}; mode = "sof"; tag = "R2";
      end else if (a == 5'b11111 && g == 5'b11111) begin
        expv = '0; tag = "R2";
      end else if (zero_runs(w) >= 2) begin
        expv = {3'b101, 4'b1110}; mode = "false"; exp_bad = 1; tag = "R7";
      end else begin
        expv = '0; tag = "R10";
      end
    end else if (mode == "sof") begin
      expv = {3'b110, 4'b0101}; mode = "frame"; tag = "R2";
    end else if (mode == "frame") begin
      if (a == 5'b01101 && g == 5'b00111) begin
        expv = '0; mode = "drain"; tag = "R5";
      end else if (a == 5'b11111 && g == 5'b11111) begin
        expv = {3'b111, 4'b0000}; mode = "quiet"; tag = "R6";
      end else begin
        d = lookup(a);
        if (d < 0) begin expv = {3'b111, 4'b0000}; tag = "R4"; end
        else begin expv = {3'b110, 4'(d)}; tag = "R3"; end
      end
    end else if (mode == "drain") begin
      expv = '0; mode = "quiet"; tag = "R5";
    end else begin
      if (a == 5'b11111 && g == 5'b11111) begin
        expv = '0; mode = "quiet"; tag = "R7";
      end else begin
        expv = {3'b101, 4'b1110};
        tag = (a == 5'b11000 && g == 5'b10001) ? "R9" : "R7";
      end
    end
  endtask

  task automatic compare();
    checks++;
    if ({crs, rx_dv, rx_er, rx_nib} !== expv) begin
      fails++;
      $display("FAIL %s: outputs {crs,dv,er,nib} actual %b expected %b", tag,
               {crs, rx_dv, rx_er, rx_nib}, expv);
    end
    checks++;
    if (bad_ssd !== exp_bad) begin
      fails++;
      $display("FAIL R8: bad_ssd actual %b expected %b (step %s)", bad_ssd, exp_bad, tag);
    end
  endtask

  task automatic send(input logic [4:0] g);
    @(negedge clk);
    compare();
    cg = g;
    @(posedge clk);
    model_step(g);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cg  = 5'b11111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: reset state visible at ports
    checks++;
    if ({crs, rx_dv, rx_er, rx_nib, bad_ssd} !== 8'b0) begin
      fails++;
      $display("FAIL R1: after reset actual %b expected %b",
               {crs, rx_dv, rx_er, rx_nib, bad_ssd}, 8'b0);
    end
  endtask

  task automatic idles(input int n);
    for (int k = 0; k < n; k++) send(5'b11111);
  endtask

  task automatic sof();
    send(5'b11000);
    send(5'b10001);
  endtask

  task automatic eof();
    send(5'b01101);
    send(5'b00111);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    idles(4);

    // R2 R3 R5: full frame with every data nibble
    sof();
    for (int k = 0; k < 16; k++) send(data_codes[k]);
    eof();
    idles(3);

    // R4: invalid symbols inside a frame, including a lone T
    sof();
    send(data_codes[5]);
    send(5'b00000);
    send(data_codes[10]);
    send(5'b01101);
    send(data_codes[3]);
    send(5'b11000);
    eof();
    idles(2);

    // R6: frame cut short by idles
    sof();
    send(data_codes[9]);
    send(data_codes[1]);
    idles(4);

    // R10: weak noise stays ignored
    send(5'b11011);
    send(5'b11111);
    send(5'b11100);
    idles(2);
    send(5'b11000);
    idles(3);

    // R7 R8 R9: false carrier, held through J,K, released by I,I
    send(data_codes[2]);
    send(data_codes[7]);
    sof();
    send(data_codes[4]);
    send(5'b11111);
    send(5'b01010);
    idles(2);
    // start right after release
    sof();
    send(data_codes[12]);
    eof();
    idles(2);

    // R8: second false carrier, bit stays set
    send(5'b01101);
    idles(3);

    // R1: reset clears sticky bit; frame works afterwards
    do_reset();
    idles(2);
    sof();
    send(data_codes[15]);
    send(data_codes[0]);
    eof();
    idles(3);

    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule